// File: doc/BRIEF.md
# Platform-Level Interrupt Controller Core

This block gathers a parameterised set of external interrupt lines and routes them to a parameterised number of hart contexts. A context is one privilege mode of one hardware thread, so the context count is set separately from any thread count. Each source carries a programmable priority and a trigger mode, either level or edge. Each context owns an enable mask over the sources and a priority threshold. A context's interrupt line is high while at least one source qualifies for it.

Software services an interrupt in two steps. A read of the context's claim word returns the identifier of the best qualifying source, and the same read takes that source out of the pending set. A later write of that identifier to the claim word ends the handler. Between claim and completion the source's gateway forwards no new request. For edge-triggered sources, edges that arrive while the handler is active are either counted and replayed one per completion, or discarded. A build-time parameter makes that choice.

Configuration goes through a synchronous word-addressed port. Read data appears in the cycle after the read strobe. The address is a 4-bit region in the upper bits and a 6-bit index in the lower bits. `DATA_W` must be larger than `N_SRC`, and `N_SRC` and `N_CTX` must both be below 64.

Top module: `plic_core`

## Requirements
- R1: After reset every priority, trigger mode, enable mask and threshold reads 0. No source is pending, every context line is low, and a claim returns 0.
- R2: Register map: region 0 holds source priorities (index = source ID, low PRIO_W bits kept). Region 1 holds trigger modes (bit 0 set = edge). Region 2 holds context enable masks (bit s = source s, bit 0 not stored). Region 3 holds context thresholds. Region 4 is claim on read and complete on write. Region 5 reads the pending set at bit s. Writes to source index 0, source indices above N_SRC and context indices at or above N_CTX are dropped, and reads of those indices return 0.
- R3: A context's line is high exactly when some source is pending, is enabled for that context, and has a priority strictly above the context threshold. A priority of 0 therefore never raises a line.
- R4: A claim read returns the qualifying source with the highest priority. When priorities are equal, the lowest ID wins. The read returns 0 when no source qualifies.
- R5: A claim clears the source's pending bit in the same edge. The source is not pending again until a completion carrying its ID has been written, even while its input stays asserted.
- R6: A level-triggered source whose input is still high when it completes is pending again one cycle after the completion write. One whose input is low stays clear.
- R7: An edge-triggered source becomes pending on a rising input. A level held high after completion does not make it pending again.
- R8: With EDGE_QUEUE=1, rising edges during an active handler are counted, saturating at 2^CNT_W-1. Each completion then replays one stored edge as a new pending request.
- R9: With EDGE_QUEUE=0, rising edges during an active handler are discarded.
- R10: A completion write is ignored if it carries ID 0, an ID above N_SRC, the ID of a source that is not active, or a context index at or above N_CTX.
- R11: Contexts are independent. A source masked off in one context neither raises that context's line nor is returned by its claim, whatever other contexts do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_src_i | input | N_SRC | Interrupt inputs, bit s is source s (s = 1..N_SRC) |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (a claim-region read claims) |
| reg_addr_i | input | 10 | Word address: region in [9:6], index in [5:0] |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data, valid the cycle after the read strobe |
| ctx_irq_o | output | N_CTX | Interrupt line per context |

## Verification
Several properties are checked on every cycle. A source is never both pending and active. A claim always moves its source into the active state. An active source stays active until its own completion. An idle level source with a high input always becomes pending. At most one source is claimed per cycle, and only a pending one. No context line rises while nothing is pending.

Some behaviours only show up in the bench's scenarios, because they need a history of events. These are the tie-breaking order and the threshold comparison seen through claim values, and the rejection of malformed completions. They also include the edge queue saturating at three and replaying, set against a second instance built in discard mode.

// File: rtl/plic_pkg.sv
// Shared constants and register-region codes for the interrupt controller core.
// Assumes a word address made of a region field over a source/context index.
package plic_pkg;
    localparam int IDX_W    = 6;
    localparam int REGION_W = 4;
    localparam int ADDR_W   = IDX_W + REGION_W;

    typedef enum logic [REGION_W-1:0] {
        RGN_PRIO   = 4'd0,
        RGN_TRIG   = 4'd1,
        RGN_ENAB   = 4'd2,
        RGN_THRESH = 4'd3,
        RGN_CLAIM  = 4'd4,
        RGN_PEND   = 4'd5
    } region_e;
endpackage

// File: rtl/plic_gateway.sv
// Per-source gateway: converts a level or edge input into one pending request,
// holds the source in service from claim until completion, and optionally
// stores edges seen during service for later replay.
// Assumes irq_i is synchronous to clk and that claim_i only pulses while pending.
module plic_gateway #(
    parameter int CNT_W      = 2,
    parameter bit EDGE_QUEUE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_i,
    input  logic edge_mode_i,
    input  logic claim_i,
    input  logic done_i,
    output logic pend_o,
    output logic busy_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic             irq_q;
    logic             pend_q;
    logic             busy_q;
    logic [CNT_W-1:0] cnt_q;
    logic             rise;
    logic             idle;
    logic             take_cnt;

    assign rise     = irq_i & ~irq_q;
    assign idle     = ~pend_q & ~busy_q & ~claim_i;
    assign take_cnt = idle & edge_mode_i & ~rise & (cnt_q != '0);

    // Track input history, pending request and in-service state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q  <= 1'b0;
            pend_q <= 1'b0;
            busy_q <= 1'b0;
        end else begin
            irq_q <= irq_i;
            if (claim_i) begin
                pend_q <= 1'b0;
                busy_q <= 1'b1;
            end else if (idle) begin
                if (edge_mode_i) pend_q <= rise | (cnt_q != '0);
                else             pend_q <= irq_i;
            end
            if (done_i && busy_q) busy_q <= 1'b0;
        end
    end

    // Edge store: counting variant or discard variant, chosen at build time.
    generate
        if (EDGE_QUEUE) begin : g_queue
            // Count edges during service, replay one whenever the gateway is idle.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else if (edge_mode_i && busy_q && rise && cnt_q != CNT_MAX) begin
                    cnt_q <= cnt_q + 1'b1;
                end else if (take_cnt) begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
        end else begin : g_drop
            assign cnt_q = '0;
        end
    endgenerate

    assign pend_o = pend_q;
    assign busy_o = busy_q;
endmodule

// File: rtl/plic_arbiter.sv
// Per-context arbiter: picks the pending, enabled source whose priority is
// highest and strictly above the threshold; ties go to the lower ID.
// Assumes source IDs 1..N_SRC; result 0 means no candidate.
module plic_arbiter #(
    parameter int N_SRC  = 8,
    parameter int PRIO_W = 3,
    parameter int ID_W   = 4
) (
    input  logic [N_SRC:1]             pend_i,
    input  logic [N_SRC:1]             en_i,
    input  logic [N_SRC:1][PRIO_W-1:0] prio_i,
    input  logic [PRIO_W-1:0]          thr_i,
    output logic [ID_W-1:0]            id_o,
    output logic                       irq_o
);
    logic [PRIO_W-1:0] best_p;

    // Linear scan seeded with the threshold; strict compare keeps the lower ID on ties.
    always_comb begin
        best_p = thr_i;
        id_o   = '0;
        for (int s = 1; s <= N_SRC; s++) begin
            if (pend_i[s] && en_i[s] && prio_i[s] > best_p) begin
                best_p = prio_i[s];
                id_o   = ID_W'(s);
            end
        end
    end

    assign irq_o = (id_o != '0);
endmodule

// File: rtl/plic_core.sv
// Interrupt controller core: configuration registers, one gateway per source,
// one arbiter per context, claim on read and completion on write.
// Assumes DATA_W > N_SRC, N_SRC < 64, N_CTX < 64, one access per cycle.
module plic_core import plic_pkg::*; #(
    parameter int N_SRC      = 8,
    parameter int N_CTX      = 2,
    parameter int PRIO_W     = 3,
    parameter int CNT_W      = 2,
    parameter bit EDGE_QUEUE = 1'b1,
    parameter int DATA_W     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC:1]    irq_src_i,
    input  logic              reg_wr_i,
    input  logic              reg_rd_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic [N_CTX-1:0]  ctx_irq_o
);
    localparam int ID_W = $clog2(N_SRC + 1);

    logic [N_SRC:1][PRIO_W-1:0] prio_q;
    logic [N_SRC:1]             edge_q;
    logic [N_CTX-1:0][N_SRC:1]  en_q;
    logic [N_CTX-1:0][PRIO_W-1:0] thr_q;
    logic [N_SRC:1]             pend_w;
    logic [N_SRC:1]             busy_w;
    logic [N_SRC:1]             claim_v;
    logic [N_SRC:1]             done_v;
    logic [N_CTX-1:0][ID_W-1:0] best_id;
    logic [REGION_W-1:0]        rgn;
    logic [IDX_W-1:0]           idx;

    assign rgn = reg_addr_i[ADDR_W-1 -: REGION_W];
    assign idx = reg_addr_i[IDX_W-1:0];

    // Configuration register writes; out-of-range indices fall through.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prio_q <= '0;
            edge_q <= '0;
            en_q   <= '0;
            thr_q  <= '0;
        end else if (reg_wr_i) begin
            for (int s = 1; s <= N_SRC; s++) begin
                if (idx == IDX_W'(s)) begin
                    if (rgn == RGN_PRIO) prio_q[s] <= reg_wdata_i[PRIO_W-1:0];
                    if (rgn == RGN_TRIG) edge_q[s] <= reg_wdata_i[0];
                end
            end
            for (int c = 0; c < N_CTX; c++) begin
                if (idx == IDX_W'(c)) begin
                    if (rgn == RGN_ENAB)   en_q[c]  <= reg_wdata_i[N_SRC:1];
                    if (rgn == RGN_THRESH) thr_q[c] <= reg_wdata_i[PRIO_W-1:0];
                end
            end
        end
    end

    // Decode claim reads and completion writes into per-source pulses.
    always_comb begin
        claim_v = '0;
        done_v  = '0;
        if (rgn == RGN_CLAIM) begin
            for (int c = 0; c < N_CTX; c++) begin
                if (idx == IDX_W'(c)) begin
                    for (int s = 1; s <= N_SRC; s++) begin
                        if (reg_rd_i && best_id[c] == ID_W'(s)) claim_v[s] = 1'b1;
                        if (reg_wr_i && reg_wdata_i == DATA_W'(s)) done_v[s] = 1'b1;
                    end
                end
            end
        end
    end

    // Registered read data, one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata_o <= '0;
        end else if (reg_rd_i) begin
            reg_rdata_o <= '0;
            for (int s = 1; s <= N_SRC; s++) begin
                if (idx == IDX_W'(s)) begin
                    if (rgn == RGN_PRIO) reg_rdata_o[PRIO_W-1:0] <= prio_q[s];
                    if (rgn == RGN_TRIG) reg_rdata_o[0]          <= edge_q[s];
                end
            end
            for (int c = 0; c < N_CTX; c++) begin
                if (idx == IDX_W'(c)) begin
                    if (rgn == RGN_ENAB)   reg_rdata_o[N_SRC:1]   <= en_q[c];
                    if (rgn == RGN_THRESH) reg_rdata_o[PRIO_W-1:0] <= thr_q[c];
                    if (rgn == RGN_CLAIM)  reg_rdata_o[ID_W-1:0]   <= best_id[c];
                end
            end
            if (rgn == RGN_PEND) reg_rdata_o[N_SRC:1] <= pend_w;
        end
    end

    generate
        for (genvar s = 1; s <= N_SRC; s++) begin : g_src
            plic_gateway #(
                .CNT_W      (CNT_W),
                .EDGE_QUEUE (EDGE_QUEUE)
            ) gw_i (
                .clk         (clk),
                .rst_n       (rst_n),
                .irq_i       (irq_src_i[s]),
                .edge_mode_i (edge_q[s]),
                .claim_i     (claim_v[s]),
                .done_i      (done_v[s]),
                .pend_o      (pend_w[s]),
                .busy_o      (busy_w[s])
            );
        end
        for (genvar c = 0; c < N_CTX; c++) begin : g_ctx
            plic_arbiter #(
                .N_SRC  (N_SRC),
                .PRIO_W (PRIO_W),
                .ID_W   (ID_W)
            ) arb_i (
                .pend_i (pend_w),
                .en_i   (en_q[c]),
                .prio_i (prio_q),
                .thr_i  (thr_q[c]),
                .id_o   (best_id[c]),
                .irq_o  (ctx_irq_o[c])
            );
        end
    endgenerate
endmodule

// File: rtl/plic_core_chk.sv
// Checker for the controller core: relates gateway state, claim and completion
// pulses and context lines over time. Attached to plic_core by bind below.
module plic_core_chk #(
    parameter int N_SRC = 8,
    parameter int N_CTX = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_SRC:1]   pend,
    input logic [N_SRC:1]   busy,
    input logic [N_SRC:1]   claim_v,
    input logic [N_SRC:1]   done_v,
    input logic [N_SRC:1]   irq_src,
    input logic [N_SRC:1]   edge_mode,
    input logic [N_CTX-1:0] ctx_irq
);
    AST_ONE_CLAIM: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(claim_v)); // R4
    AST_QUIET_LINES: assert property (@(posedge clk) disable iff (!rst_n)
        (pend == '0) |-> (ctx_irq == '0)); // R3

    generate
        for (genvar s = 1; s <= N_SRC; s++) begin : g_s
            AST_PEND_BUSY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
                !(pend[s] && busy[s])); // R5
            AST_CLAIM_OF_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
                claim_v[s] |-> pend[s]); // R4
            AST_CLAIM_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
                claim_v[s] |=> (busy[s] && !pend[s])); // R5
            AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
                (busy[s] && !done_v[s]) |=> busy[s]); // R5
            AST_DONE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
                (busy[s] && done_v[s]) |=> !busy[s]); // R10
            AST_LEVEL_REPEND: assert property (@(posedge clk) disable iff (!rst_n)
                (!busy[s] && !pend[s] && !edge_mode[s] && irq_src[s]) |=> pend[s]); // R6
        end
    endgenerate
endmodule

bind plic_core plic_core_chk #(
    .N_SRC (N_SRC),
    .N_CTX (N_CTX)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .pend      (pend_w),
    .busy      (busy_w),
    .claim_v   (claim_v),
    .done_v    (done_v),
    .irq_src   (irq_src_i),
    .edge_mode (edge_q),
    .ctx_irq   (ctx_irq_o)
);

// File: tb/plic_core_tb_top.sv
`timescale 1ns/1ps
// Bench: register table walk, then directed claim/complete and gateway scenarios
// on a queueing instance and a discarding instance fed the same stimulus.
module plic_core_tb_top;
    localparam int N_SRC = 8;
    localparam int N_CTX = 2;

    typedef struct packed {
        logic [9:0]  addr;
        logic [31:0] wdata;
        logic [31:0] exp;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{10'h001, 32'h0000_0005, 32'h0000_0005},
        '{10'h008, 32'h0000_00FF, 32'h0000_0007},
        '{10'h043, 32'h0000_0003, 32'h0000_0001},
        '{10'h080, 32'h0000_01FF, 32'h0000_01FE},
        '{10'h081, 32'hFFFF_FFFF, 32'h0000_01FE},
        '{10'h0C1, 32'h0000_0002, 32'h0000_0002},
        '{10'h000, 32'h0000_0007, 32'h0000_0000},
        '{10'h0C5, 32'h0000_0003, 32'h0000_0000}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [N_SRC:1]   irq = '0;
    logic             wr = 1'b0;
    logic             rd = 1'b0;
    logic [9:0]       addr = '0;
    logic [31:0]      wdata = '0;
    logic [31:0]      rdata_q, rdata_d;
    logic [N_CTX-1:0] line_q, line_d;
    int               n_chk = 0;
    int               n_bad = 0;

    always #4 clk = ~clk;

    plic_core #(.N_SRC(N_SRC), .N_CTX(N_CTX), .EDGE_QUEUE(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .irq_src_i(irq), .reg_wr_i(wr), .reg_rd_i(rd),
        .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata_q), .ctx_irq_o(line_q));

    plic_core #(.N_SRC(N_SRC), .N_CTX(N_CTX), .EDGE_QUEUE(1'b0)) dut_drop_i (
        .clk(clk), .rst_n(rst_n), .irq_src_i(irq), .reg_wr_i(wr), .reg_rd_i(rd),
        .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata_d), .ctx_irq_o(line_d));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic reg_write(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic reg_read(input logic [9:0] a);
        @(negedge clk);
        rd = 1'b1; addr = a;
        @(negedge clk);
        rd = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual 100000 cycles, expected completion earlier");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        // R1: reset state
        @(negedge clk);
        check("R1 lines", 32'(line_q), 32'h0);
        reg_read(10'h140); check("R1 pending", rdata_q, 32'h0);
        reg_read(10'h100); check("R1 claim", rdata_q, 32'h0);

        // R2: register map walk
        for (int i = 0; i < 8; i++) begin
            reg_write(VECS[i].addr, VECS[i].wdata);
            reg_read(VECS[i].addr);
            check("R2 readback", rdata_q, VECS[i].exp);
        end

        do_reset();
        reg_read(10'h001); check("R1 prio cleared", rdata_q, 32'h0);

        reg_write(10'h002, 3);
        reg_write(10'h005, 3);
        reg_write(10'h006, 6);
        reg_write(10'h004, 4);
        reg_write(10'h080, 32'h1FE);
        reg_write(10'h081, 32'h040);

        irq[2] = 1'b1; irq[5] = 1'b1;
        @(negedge clk);
        check("R3 line ctx0", 32'(line_q[0]), 32'h1);
        check("R11 line ctx1 masked", 32'(line_q[1]), 32'h0);
        reg_read(10'h101); check("R11 claim ctx1 masked", rdata_q, 32'h0);
        reg_read(10'h100); check("R4 tie lower id", rdata_q, 32'd2);
        check("R3 line with one left", 32'(line_q[0]), 32'h1);
        reg_read(10'h100); check("R4 second claim", rdata_q, 32'd5);
        check("R5 line after claims", 32'(line_q[0]), 32'h0);
        repeat (3) @(negedge clk);
        reg_read(10'h140); check("R5 no repend while active", rdata_q, 32'h0);

        irq[5] = 1'b0;
        reg_write(10'h100, 2);
        @(negedge clk);
        check("R6 level repend", 32'(line_q[0]), 32'h1);
        reg_write(10'h100, 5);
        @(negedge clk);
        reg_read(10'h140); check("R6 low level stays clear", rdata_q, 32'h004);

        reg_write(10'h0C0, 3);
        check("R3 equal to threshold", 32'(line_q[0]), 32'h0);
        reg_write(10'h0C0, 2);
        check("R3 above threshold", 32'(line_q[0]), 32'h1);
        reg_read(10'h100); check("R4 claim after threshold", rdata_q, 32'd2);
        irq[2] = 1'b0;
        reg_write(10'h100, 2);

        irq[6] = 1'b1; irq[5] = 1'b1;
        @(negedge clk);
        check("R11 line ctx1 enabled", 32'(line_q[1]), 32'h1);
        reg_read(10'h100); check("R4 higher priority", rdata_q, 32'd6);
        reg_read(10'h100); check("R4 next priority", rdata_q, 32'd5);
        check("R11 ctx1 after claim", 32'(line_q[1]), 32'h0);

        // R10: malformed completions for source 5
        reg_write(10'h100, 0);
        reg_write(10'h100, 9);
        reg_write(10'h105, 5);
        @(negedge clk);
        check("R10 bad completes ignored", 32'(line_q[0]), 32'h0);
        reg_write(10'h100, 5);
        @(negedge clk);
        check("R10 good complete", 32'(line_q[0]), 32'h1);
        reg_read(10'h100); check("R10 reclaim", rdata_q, 32'd5);
        irq[5] = 1'b0; irq[6] = 1'b0;
        reg_write(10'h100, 5);
        reg_write(10'h100, 6);

        // R3: priority 0 never qualifies
        irq[7] = 1'b1;
        repeat (2) @(negedge clk);
        check("R3 prio zero line", 32'(line_q[0]), 32'h0);
        reg_read(10'h100); check("R4 none qualifies", rdata_q, 32'h0);
        irq[7] = 1'b0;

        // R7/R8/R9: edge source 4
        reg_write(10'h044, 1);
        irq[4] = 1'b1;
        @(negedge clk);
        check("R7 edge pends queue", 32'(line_q[0]), 32'h1);
        check("R7 edge pends drop", 32'(line_d[0]), 32'h1);
        reg_read(10'h100);
        check("R7 claim queue", rdata_q, 32'd4);
        check("R7 claim drop", rdata_d, 32'd4);
        reg_write(10'h100, 4);
        repeat (2) @(negedge clk);
        check("R7 held high no repend", 32'(line_q[0]), 32'h0);
        check("R7 held high no repend drop", 32'(line_d[0]), 32'h0);
        irq[4] = 1'b0;
        @(negedge clk);
        irq[4] = 1'b1;
        @(negedge clk);
        reg_read(10'h100);
        check("R7 new edge claim", rdata_q, 32'd4);
        for (int k = 0; k < 4; k++) begin
            irq[4] = 1'b0;
            @(negedge clk);
            irq[4] = 1'b1;
            @(negedge clk);
        end
        irq[4] = 1'b0;
        reg_write(10'h100, 4);
        @(negedge clk);
        check("R8 replay line", 32'(line_q[0]), 32'h1);
        check("R9 discarded line", 32'(line_d[0]), 32'h0);
        for (int k = 0; k < 3; k++) begin
            reg_read(10'h100);
            check("R8 replayed claim", rdata_q, 32'd4);
            check("R9 no replay claim", rdata_d, 32'h0);
            reg_write(10'h100, 4);
            @(negedge clk);
        end
        check("R8 saturated at three", 32'(line_q[0]), 32'h0);
        reg_read(10'h100); check("R8 queue empty", rdata_q, 32'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule